// File: doc/BRIEF.md
# Memory/IO Bus Cycle Sequencer

This block is the master side of a shared address/data bus. A requester hands it a single transfer: an address, write data, a direction bit and a space bit. The sequencer then plays out that one bus cycle in a fixed step order. First it sets up the address, plus the outgoing data for a write. Only after that does it raise the read or write strobe. It holds the strobe until the slave signals ready, then drops the strobe and gives a one-cycle completion pulse.

A dedicated space line tells slaves whether the cycle targets memory or the I/O port space. Both spaces share the same address and data lines. A read in I/O space is a port input into the requester. A write in I/O space is a port output. The data bus is split into a driven value, an enable for the external tri-state driver, and a returned value, so the block stays free of bidirectional ports.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset the block is idle: busy_o, done_o, bus_rd_o, bus_wr_o, bus_doe_o and bus_io_o are all 0, and rdata_o is 0.
- R2: A request is taken only in idle. The cycle after acceptance is a setup cycle. In it, bus_addr_o carries the request address and no strobe is active. The strobe rises one cycle later, with the address unchanged.
- R3: On a read, rdata_o takes the value of bus_din_i that is present at the clock edge where bus_rdy_i is sampled high with bus_rd_o active. It holds that value until the next read completes.
- R4: On a write, bus_dout_o carries the write data and bus_doe_o is 1 from the setup cycle through the last strobe cycle. The write strobe rises only after that data has been on the bus for a cycle.
- R5: The strobe stays high for 1 + N cycles, where N is the number of strobe cycles in which bus_rdy_i is sampled low. The value of bus_rdy_i during the setup cycle has no effect.
- R6: done_o is high for exactly one cycle: the first cycle after the strobe falls. busy_o returns to 0 in the cycle after that.
- R7: bus_io_o equals the request's space bit (0 = memory, 1 = I/O) for every cycle in which busy_o is 1. It stays constant across the transfer.
- R8: bus_doe_o is 0 in every cycle of a read transfer, in the completion cycle and in idle.
- R9: A request raised while busy_o is 1 is ignored. Address, data, direction and space of the transfer in progress stay unchanged, and no extra transfer follows.
- R10: bus_rd_o and bus_wr_o are never 1 in the same cycle.
- R11: A write transfer leaves rdata_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transfer request, taken when idle |
| req_addr_i | input | AW | Transfer address |
| req_wdata_i | input | DW | Data for a write |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_io_i | input | 1 | 1 = I/O space, 0 = memory space |
| busy_o | output | 1 | A transfer is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DW | Data captured by the last read |
| bus_addr_o | output | AW | Bus address |
| bus_dout_o | output | DW | Data driven to the bus |
| bus_doe_o | output | 1 | Data driver enable |
| bus_din_i | input | DW | Data returned from the bus |
| bus_rd_o | output | 1 | Read strobe |
| bus_wr_o | output | 1 | Write strobe |
| bus_io_o | output | 1 | Space select, 1 = I/O cycle |
| bus_rdy_i | input | 1 | Slave ready, sampled every clock |

## Verification
The bench builds the block with AW = 12 and DW = 8, in place of the 16-bit defaults. These narrow widths let random addresses and data reach the top bits and the all-ones values within a few dozen transfers. Wait lengths from zero to several cycles, in both spaces and both directions, reach the single-cycle strobe and stretched strobes. Junk requests raised during busy cycles, and ready raised during setup, reach the ignored-input cases.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_END    = 2'd3
  } seq_state_e;
endpackage

// File: rtl/bcs_ctrl.sv
module bcs_ctrl
  import bus_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       rdy_i,
  input  logic       write_q_i,
  output seq_state_e state_o,
  output logic       load_o,
  output logic       capture_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_i) state_d = ST_SETUP;
      ST_SETUP:  state_d = ST_STROBE;
      ST_STROBE: if (rdy_i) state_d = ST_END;
      ST_END:    state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o   = state_q;
  assign load_o    = (state_q == ST_IDLE) && req_i;
  assign capture_o = (state_q == ST_STROBE) && rdy_i && !write_q_i;
endmodule

// File: rtl/bcs_hold.sv
module bcs_hold #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          write_i,
  input  logic          io_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          write_o,
  output logic          io_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      wdata_o <= '0;
      write_o <= 1'b0;
      io_o    <= 1'b0;
    end else if (load_i) begin
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
      write_o <= write_i;
      io_o    <= io_i;
    end
  end
endmodule

// File: rtl/bcs_rdata.sv
module bcs_rdata #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          capture_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_o <= '0;
    else if (capture_i) rdata_o <= din_i;
  end
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bus_seq_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic          req_write_i,
  input  logic          req_io_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_dout_o,
  output logic          bus_doe_o,
  input  logic [DW-1:0] bus_din_i,
  output logic          bus_rd_o,
  output logic          bus_wr_o,
  output logic          bus_io_o,
  input  logic          bus_rdy_i
);
  seq_state_e state;
  logic       load, capture;
  logic       write_q, io_q;
  logic       strobe, drive_phase;

  bcs_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .rdy_i     (bus_rdy_i),
    .write_q_i (write_q),
    .state_o   (state),
    .load_o    (load),
    .capture_o (capture)
  );

  bcs_hold #(.AW(AW), .DW(DW)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .addr_i  (req_addr_i),
    .wdata_i (req_wdata_i),
    .write_i (req_write_i),
    .io_i    (req_io_i),
    .addr_o  (bus_addr_o),
    .wdata_o (bus_dout_o),
    .write_o (write_q),
    .io_o    (io_q)
  );

  bcs_rdata #(.DW(DW)) u_rdata (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture),
    .din_i     (bus_din_i),
    .rdata_o   (rdata_o)
  );

  assign strobe      = (state == ST_STROBE);
  assign drive_phase = (state == ST_SETUP) || strobe;
  assign busy_o      = (state != ST_IDLE);
  assign done_o      = (state == ST_END);
  assign bus_rd_o    = strobe && !write_q;
  assign bus_wr_o    = strobe && write_q;
  assign bus_doe_o   = drive_phase && write_q;
  assign bus_io_o    = busy_o && io_q;
endmodule

// File: rtl/bcs_chk.sv
module bcs_chk #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          done_o,
  input logic [DW-1:0] rdata_o,
  input logic [AW-1:0] bus_addr_o,
  input logic [DW-1:0] bus_dout_o,
  input logic          bus_doe_o,
  input logic [DW-1:0] bus_din_i,
  input logic          bus_rd_o,
  input logic          bus_wr_o,
  input logic          bus_io_o,
  input logic          bus_rdy_i
);
  // R10
  rd_wr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_rd_o && bus_wr_o));

  // R2
  rd_after_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_rd_o) |-> $past(busy_o) && $stable(bus_addr_o));

  // R4
  wr_after_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_wr_o) |-> $past(bus_doe_o) && $stable(bus_dout_o) && $stable(bus_addr_o));

  // R5
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_o && !bus_rdy_i) |=> bus_rd_o);

  // R5
  wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_o && !bus_rdy_i) |=> bus_wr_o);

  // R6
  done_after_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((bus_rd_o || bus_wr_o) && bus_rdy_i) |=> done_o && !bus_rd_o && !bus_wr_o);

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);

  // R7
  io_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(bus_io_o));

  // R8
  doe_not_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_doe_o |-> !bus_rd_o && busy_o && !done_o);

  // R9
  addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(bus_addr_o));

  // R3
  rdata_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_o && bus_rdy_i) |=> rdata_o == $past(bus_din_i));

  // R11
  rdata_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wr_o |=> $stable(rdata_o));
endmodule

bind bus_cycle_seq bcs_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .rdata_o    (rdata_o),
  .bus_addr_o (bus_addr_o),
  .bus_dout_o (bus_dout_o),
  .bus_doe_o  (bus_doe_o),
  .bus_din_i  (bus_din_i),
  .bus_rd_o   (bus_rd_o),
  .bus_wr_o   (bus_wr_o),
  .bus_io_o   (bus_io_o),
  .bus_rdy_i  (bus_rdy_i)
);

// File: tb/bus_cycle_seq_bench.sv
module bus_cycle_seq_bench;
  localparam int unsigned AW = 12;
  localparam int unsigned DW = 8;
  localparam time CLK_PERIOD = 10ns;
  localparam int unsigned WDOG_CYCLES = 20000;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [DW-1:0] req_wdata_i = '0;
  logic          req_write_i = 1'b0;
  logic          req_io_i = 1'b0;
  logic          busy_o, done_o, bus_doe_o, bus_rd_o, bus_wr_o, bus_io_o;
  logic [DW-1:0] rdata_o, bus_dout_o;
  logic [AW-1:0] bus_addr_o;
  logic [DW-1:0] bus_din_i = '0;
  logic          bus_rdy_i = 1'b0;

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;
  bit          ended = 1'b0;
  logic [DW-1:0] exp_rdata = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bus_cycle_seq #(.AW(AW), .DW(DW)) u_bus_cycle_seq (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic logic [DW-1:0] next_rdata(input logic [DW-1:0] cur, input bit wr,
                                               input logic [DW-1:0] din);
    return wr ? cur : din;
  endfunction

  // One full transfer, checked cycle by cycle at falling edges.
  task automatic run_txn(input logic [AW-1:0] a, input logic [DW-1:0] wd, input bit wr,
                         input bit io, input int unsigned nwait, input logic [DW-1:0] din,
                         input bit setup_rdy);
    int unsigned strobes;
    @(negedge clk_i);
    chk(!busy_o, "R2 idle before request", busy_o, 0);
    req_i = 1'b1; req_addr_i = a; req_wdata_i = wd; req_write_i = wr; req_io_i = io;
    @(negedge clk_i);
    // setup cycle; junk request while busy (R9)
    req_addr_i = ~a; req_wdata_i = ~wd; req_write_i = ~wr; req_io_i = ~io;
    bus_rdy_i = setup_rdy;
    chk(busy_o && !bus_rd_o && !bus_wr_o, "R2 setup no strobe", {bus_rd_o, bus_wr_o}, 0);
    chk(bus_addr_o == a, "R2 setup addr", bus_addr_o, a);
    chk(bus_io_o == io, "R7 setup space", bus_io_o, io);
    chk(bus_doe_o == wr, "R8 setup doe", bus_doe_o, wr);
    if (wr) chk(bus_dout_o == wd, "R4 setup data", bus_dout_o, wd);
    strobes = 0;
    for (int k = 0; k <= int'(nwait); k++) begin
      @(negedge clk_i);
      bus_rdy_i = (k == int'(nwait));
      bus_din_i = (k == int'(nwait)) ? din : DW'($urandom);
      if ((wr ? bus_wr_o : bus_rd_o)) strobes++;
      chk((wr ? !bus_rd_o : !bus_wr_o), "R10 one strobe", {bus_rd_o, bus_wr_o}, wr ? 1 : 2);
      chk(bus_addr_o == a, "R9 addr held", bus_addr_o, a);
      chk(bus_io_o == io, "R7 space held", bus_io_o, io);
      chk(bus_doe_o == wr, "R8 doe in strobe", bus_doe_o, wr);
      if (wr) chk(bus_dout_o == wd, "R4 data held", bus_dout_o, wd);
      chk(!done_o, "R6 no early done", done_o, 0);
    end
    @(negedge clk_i);
    req_i = 1'b0;
    bus_rdy_i = 1'b0;
    exp_rdata = next_rdata(exp_rdata, wr, din);
    chk(strobes == nwait + 1, "R5 strobe length", strobes, nwait + 1);
    chk(done_o && !bus_rd_o && !bus_wr_o, "R6 done after strobe", {done_o, bus_rd_o, bus_wr_o}, 4);
    chk(!bus_doe_o, "R8 doe off at done", bus_doe_o, 0);
    chk(bus_io_o == io, "R7 space at done", bus_io_o, io);
    chk(rdata_o == exp_rdata, wr ? "R11 rdata kept" : "R3 rdata captured", rdata_o, exp_rdata);
    @(negedge clk_i);
    chk(!done_o && !busy_o, "R6 single pulse", {done_o, busy_o}, 0);
    chk(!bus_rd_o && !bus_wr_o && !bus_doe_o && !bus_io_o, "R9 no extra transfer",
        {bus_rd_o, bus_wr_o, bus_doe_o, bus_io_o}, 0);
    chk(rdata_o == exp_rdata, "R3 rdata holds", rdata_o, exp_rdata);
  endtask

  initial begin
    int unsigned cyc = 0;
    while (cyc < WDOG_CYCLES) begin
      @(posedge clk_i);
      cyc++;
    end
    chk(1'b0, "watchdog", cyc, WDOG_CYCLES);
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    #(CLK_PERIOD * 2);
    @(negedge clk_i);
    chk(!busy_o && !done_o && !bus_rd_o && !bus_wr_o && !bus_doe_o && !bus_io_o,
        "R1 reset outputs", {busy_o, done_o, bus_rd_o, bus_wr_o, bus_doe_o, bus_io_o}, 0);
    chk(rdata_o == '0, "R1 reset rdata", rdata_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o, "R1 idle after reset", busy_o, 0);

    // directed corners
    run_txn('0, '0, 1'b0, 1'b0, 0, '1, 1'b0);        // memory read, no wait
    run_txn('1, 8'hA5, 1'b1, 1'b1, 5, 8'h00, 1'b1);  // I/O output, long wait, ready in setup
    run_txn(12'h0F0, 8'h3C, 1'b1, 1'b0, 0, 8'h77, 1'b1); // memory write, no wait (R11)
    run_txn(12'h800, '0, 1'b0, 1'b1, 3, 8'h5A, 1'b1);    // I/O input, ready in setup ignored

    for (int i = 0; i < 40; i++) begin
      run_txn(AW'($urandom), DW'($urandom), 1'($urandom), 1'($urandom),
              $urandom_range(0, 4), DW'($urandom), 1'($urandom));
    end
    finish_run();
  end
endmodule